// File: doc/BRIEF.md
# Host Write Plane Router

This block takes one host byte write per clock and decides where it lands in display memory. The memory is split into planes, four by default. In the planar modes the block raises one write enable per plane and produces the address inside the plane. That address depends on how the host address is interleaved across the planes. In the packed pixel mode the planes are bypassed, and the byte goes to a linear byte address instead.

Plane selection comes from the per-plane write mask. Two interleaving modes can narrow it further. In four-way chaining, the low address bits pick exactly one plane. In two-way pairing, address bit 0 must match plane bit 0. When both are on, both conditions apply. Any data transformation is done upstream, and the write byte passes through unchanged. A multi-byte host access is fed in as consecutive single-byte writes, one per clock.

All outputs are registered, so a write presented in one cycle appears at the outputs after the next rising clock edge.

Top module: `hwpr_top`

## Requirements
- R1: While reset is asserted, every plane enable, the linear enable, the plane address, the linear address and the data output are zero.
- R2: A strobed write presented before a rising edge shows on the outputs right after that edge. A cycle without the strobe raises no enable, and it leaves the address and data outputs holding their previous values.
- R3: In a planar write, plane j (enable bit j) is enabled only if bit j of the write mask is set.
- R4: A planar write with an all-zero write mask enables no plane and does not enable the linear port.
- R5: With four-way chaining on, only the plane whose index equals host address bits [1:0] may be enabled, and the plane address is the host address shifted right by 2.
- R6: With two-way pairing on, only planes whose index bit 0 equals host address bit 0 may be enabled, and the plane address is the host address shifted right by 1.
- R7: With both modes on, a plane must meet both the chaining and the pairing condition. The plane address uses the shift by 2.
- R8: With neither mode on, every plane set in the mask is enabled, and the plane address equals the host address.
- R9: In packed mode, a strobed write raises the linear enable and no plane enable. The linear address equals the full host byte address, including bits [1:0]. The write mask, chaining and pairing have no effect.
- R10: On every strobed write, the data output takes the write byte unchanged and the linear address takes the host address. The plane address takes the translated address whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host byte write strobe |
| host_addr | input | ADDR_W | Host byte address |
| wr_data | input | DATA_W | Write byte, already transformed |
| map_mask | input | NUM_PLANES | Per-plane write mask |
| chain4_en | input | 1 | Four-way chained interleave |
| oddeven_en | input | 1 | Two-way paired interleave |
| packed_en | input | 1 | Packed pixel linear bypass |
| plane_we | output | NUM_PLANES | Registered per-plane write enables |
| plane_addr | output | ADDR_W | Registered address within a plane |
| lin_we | output | 1 | Registered linear write enable |
| lin_addr | output | ADDR_W | Registered linear byte address |
| out_data | output | DATA_W | Registered write byte |

## Verification
The bench builds the router with a 10-bit address, four planes and an 8-bit data path. The short address lets random stimulus reach the all-ones and all-zero addresses, and every low-bit plane selection, many times over. Every combination of the three mode bits is driven against every mask value, including the zero mask in both planar and packed mode. Idle cycles between writes expose whether enables clear and whether addresses hold their values.

// File: rtl/hwpr_pkg.sv
package hwpr_pkg;
  // How the host address is folded onto a plane address
  typedef enum logic [1:0] {
    XL_FLAT = 2'd0,
    XL_PAIR = 2'd1,
    XL_QUAD = 2'd2
  } xlate_e;
endpackage

// File: rtl/hwpr_mode_decode.sv
module hwpr_mode_decode
  import hwpr_pkg::*;
(
  input  logic   chain4_en,
  input  logic   oddeven_en,
  input  logic   packed_en,
  output xlate_e xlate,
  output logic   planar_path,
  output logic   linear_path
);
  always_comb begin
    if (chain4_en)       xlate = XL_QUAD;
    else if (oddeven_en) xlate = XL_PAIR;
    else                 xlate = XL_FLAT;
    linear_path = packed_en;
    planar_path = ~packed_en;
  end
endmodule

// File: rtl/hwpr_addr_xlate.sv
module hwpr_addr_xlate
  import hwpr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_PLANES = 4
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  xlate_e            xlate,
  output logic [ADDR_W-1:0] plane_addr
);
  localparam int SEL_W = $clog2(NUM_PLANES);

  always_comb begin
    unique case (xlate)
      XL_QUAD: plane_addr = host_addr >> SEL_W;
      XL_PAIR: plane_addr = host_addr >> 1;
      default: plane_addr = host_addr;
    endcase
  end
endmodule

// File: rtl/hwpr_plane_gate.sv
module hwpr_plane_gate #(
  parameter int NUM_PLANES = 4
) (
  input  logic [$clog2(NUM_PLANES)-1:0] addr_lo,
  input  logic [NUM_PLANES-1:0]         map_mask,
  input  logic                          chain4_en,
  input  logic                          oddeven_en,
  input  logic                          planar_go,
  output logic [NUM_PLANES-1:0]         plane_hit
);
  localparam int SEL_W = $clog2(NUM_PLANES);

  for (genvar j = 0; j < NUM_PLANES; j++) begin : g_plane
    logic chain_ok;
    logic pair_ok;
    always_comb begin
      chain_ok     = ~chain4_en  | (addr_lo == SEL_W'(j));
      pair_ok      = ~oddeven_en | (addr_lo[0] == j[0]);
      plane_hit[j] = planar_go & map_mask[j] & chain_ok & pair_ok;
    end
  end
endmodule

// File: rtl/hwpr_top.sv
module hwpr_top
  import hwpr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_PLANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_PLANES-1:0] map_mask,
  input  logic                  chain4_en,
  input  logic                  oddeven_en,
  input  logic                  packed_en,
  output logic [NUM_PLANES-1:0] plane_we,
  output logic [ADDR_W-1:0]     plane_addr,
  output logic                  lin_we,
  output logic [ADDR_W-1:0]     lin_addr,
  output logic [DATA_W-1:0]     out_data
);
  localparam int SEL_W = $clog2(NUM_PLANES);

  xlate_e                  xlate;
  logic                    planar_path;
  logic                    linear_path;
  logic [ADDR_W-1:0]       xl_addr;
  logic [NUM_PLANES-1:0]   hit;

  logic [NUM_PLANES-1:0]   plane_we_d;
  logic                    lin_we_d;
  logic [ADDR_W-1:0]       plane_addr_d;
  logic [ADDR_W-1:0]       lin_addr_d;
  logic [DATA_W-1:0]       out_data_d;

  hwpr_mode_decode u_dec (
    .chain4_en   (chain4_en),
    .oddeven_en  (oddeven_en),
    .packed_en   (packed_en),
    .xlate       (xlate),
    .planar_path (planar_path),
    .linear_path (linear_path)
  );

  hwpr_addr_xlate #(.ADDR_W(ADDR_W), .NUM_PLANES(NUM_PLANES)) u_xl (
    .host_addr  (host_addr),
    .xlate      (xlate),
    .plane_addr (xl_addr)
  );

  hwpr_plane_gate #(.NUM_PLANES(NUM_PLANES)) u_gate (
    .addr_lo    (host_addr[SEL_W-1:0]),
    .map_mask   (map_mask),
    .chain4_en  (chain4_en),
    .oddeven_en (oddeven_en),
    .planar_go  (wr_stb & planar_path),
    .plane_hit  (hit)
  );

  // Next-state
  always_comb begin
    plane_we_d   = hit;
    lin_we_d     = wr_stb & linear_path;
    plane_addr_d = plane_addr;
    lin_addr_d   = lin_addr;
    out_data_d   = out_data;
    if (wr_stb) begin
      plane_addr_d = xl_addr;
      lin_addr_d   = host_addr;
      out_data_d   = wr_data;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_we   <= '0;
      lin_we     <= 1'b0;
      plane_addr <= '0;
      lin_addr   <= '0;
      out_data   <= '0;
    end else begin
      plane_we   <= plane_we_d;
      lin_we     <= lin_we_d;
      plane_addr <= plane_addr_d;
      lin_addr   <= lin_addr_d;
      out_data   <= out_data_d;
    end
  end

  // Assertions
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (plane_we == '0) && !lin_we);

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !packed_en |=> (plane_we & ~$past(map_mask)) == '0);

  p_zero_mask_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !packed_en && (map_mask == '0) |=> (plane_we == '0) && !lin_we);

  p_chain_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !packed_en && chain4_en |=> $onehot0(plane_we));

  p_packed_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && packed_en |=> lin_we && (plane_we == '0) && (lin_addr == $past(host_addr)));

  p_data_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> out_data == $past(wr_data));
endmodule

// File: tb/hwpr_top_test.sv
`timescale 1ns/1ps
module hwpr_top_test;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_stb;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] wr_data;
  logic [NP-1:0] map_mask;
  logic chain4_en, oddeven_en, packed_en;
  logic [NP-1:0] plane_we;
  logic [AW-1:0] plane_addr;
  logic lin_we;
  logic [AW-1:0] lin_addr;
  logic [DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  // reference state: what the outputs should show after the next edge
  logic [NP-1:0] e_pwe = '0;
  logic          e_lwe = 1'b0;
  logic [AW-1:0] e_paddr = '0;
  logic [AW-1:0] e_laddr = '0;
  logic [DW-1:0] e_data = '0;
  string         e_tag = "R2";

  always #2.5 clk = ~clk;

  hwpr_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_PLANES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .host_addr(host_addr),
    .wr_data(wr_data), .map_mask(map_mask), .chain4_en(chain4_en),
    .oddeven_en(oddeven_en), .packed_en(packed_en), .plane_we(plane_we),
    .plane_addr(plane_addr), .lin_we(lin_we), .lin_addr(lin_addr),
    .out_data(out_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "plane_we", int'(plane_we), int'(e_pwe));
    chk(e_tag, "lin_we", int'(lin_we), int'(e_lwe));
    chk(e_tag, "plane_addr", int'(plane_addr), int'(e_paddr));
    chk("R10", "lin_addr", int'(lin_addr), int'(e_laddr));
    chk("R10", "out_data", int'(out_data), int'(e_data));
  endtask

  // Drive one cycle: called at a negedge, compares the previous result first
  task automatic step(input logic s, input int a, input int d, input int m,
                      input logic c4, input logic oe, input logic pk);
    compare_all();
    wr_stb = s; host_addr = AW'(a); wr_data = DW'(d); map_mask = NP'(m);
    chain4_en = c4; oddeven_en = oe; packed_en = pk;
    e_pwe = '0; e_lwe = 1'b0;
    if (s) begin
      e_data  = DW'(d);
      e_laddr = AW'(a);
      if (c4)      e_paddr = AW'(a / 4);
      else if (oe) e_paddr = AW'(a / 2);
      else         e_paddr = AW'(a);
      if (pk) begin
        e_lwe = 1'b1;
        e_tag = "R9";
      end else begin
        for (int j = 0; j < NP; j++) begin
          bit ok = ((m >> j) & 1) != 0;
          if (c4 && (j != (a % NP))) ok = 0;
          if (oe && ((j % 2) != (a % 2))) ok = 0;
          e_pwe[j] = ok;
        end
        if (m % (1 << NP) == 0) e_tag = "R4";
        else if (c4 && oe)      e_tag = "R7";
        else if (c4)            e_tag = "R5";
        else if (oe)            e_tag = "R6";
        else                    e_tag = "R8";
      end
    end else begin
      e_tag = "R2";
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_stb = 0; host_addr = '1; wr_data = '1; map_mask = '1;
    chain4_en = 0; oddeven_en = 0; packed_en = 0;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero even with active-looking inputs
    wr_stb = 1;
    @(negedge clk);
    chk("R1", "plane_we", int'(plane_we), 0);
    chk("R1", "lin_we", int'(lin_we), 0);
    chk("R1", "plane_addr", int'(plane_addr), 0);
    chk("R1", "lin_addr", int'(lin_addr), 0);
    chk("R1", "out_data", int'(out_data), 0);
    wr_stb = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 flat, full mask
    step(1, 'h123, 'hA5, 'hF, 0, 0, 0);
    // R2 idle holds addresses
    step(0, 'h3FF, 'h00, 'hF, 0, 0, 0);
    // R3 partial mask
    step(1, 'h2, 'h11, 'h5, 0, 0, 0);
    // R4 zero mask planar
    step(1, 'h7, 'h22, 'h0, 0, 0, 0);
    // R5 chaining, every low-bit selection
    for (int k = 0; k < 4; k++) step(1, 'h3F0 + k, 'h30 + k, 'hF, 1, 0, 0);
    step(1, 'h3FE, 'h44, 'hB, 1, 0, 0);
    // R6 pairing, both parities
    step(1, 'h100, 'h55, 'hF, 0, 1, 0);
    step(1, 'h101, 'h66, 'hF, 0, 1, 0);
    // R7 both modes
    step(1, 'h3FF, 'h77, 'hF, 1, 1, 0);
    step(1, 'h002, 'h78, 'hE, 1, 1, 0);
    // R9 packed, zero mask and modes ignored
    step(1, 'h3FF, 'h88, 'h0, 1, 1, 1);
    step(1, 'h001, 'h99, 'hF, 0, 0, 1);
    step(0, 'h000, 'h00, 'h0, 0, 0, 0);
    step(1, 'h000, 'hFF, 'h1, 0, 0, 0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom);
      step((r % 5) != 0, int'($urandom % (1 << AW)), int'($urandom % 256),
           int'($urandom % 16), r[4], r[5], (r[8:6] == 3'd0));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    compare_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule